// File: doc/BRIEF.md
# Two-Wire Bus Speed-Mode Tracker

This block watches the clock and data lines of a two-wire serial bus using a fast system clock. It cleans up both lines and finds the bus conditions that frame each transfer. It also keeps track of whether the bus is running at standard/fast speed or at high speed.

Each raw line first passes through a two-stage synchroniser. It then goes through a counter-based glitch filter. The filter length is one of two parameters, given in system clock cycles, and `hs_mode` chooses which one applies.

From the filtered lines the block produces one-cycle START and STOP strobes. After every START it collects the first eight bits, sampled on the rising clock edges, and tests them against the high-speed master-code pattern. A matching byte switches the block into high-speed mode. Any STOP switches it back.

Downstream slave logic uses the filtered lines, the strobes and the mode flag. The block never drives the bus and never acknowledges any byte.

Top module: `i2c_speed_tracker`

## Requirements
- R1: After reset, `hs_mode` is 0, `scl_filt` and `sda_filt` are both 1, and neither strobe is asserted.
- R2: When filtered data falls while filtered clock is high in both the previous and the current cycle, `start_pulse` is high for exactly one system clock cycle.
- R3: When filtered data rises while filtered clock is high, `stop_pulse` is high for exactly one cycle, and `hs_mode` is 0 in the cycle that follows.
- R4: Data changes made while the clock line is low produce neither `start_pulse` nor `stop_pulse`.
- R5: The first byte after a START is shifted in MSB first on rising filtered-clock edges. If its upper five bits are 00001, `hs_mode` becomes 1 after the eighth rising edge.
- R6: A first byte after START that does not match the pattern leaves `hs_mode` unchanged. A matching byte in any later position also leaves `hs_mode` unchanged.
- R7: A repeated START while in high-speed mode keeps `hs_mode` at 1, even when the byte after it is not a master code.
- R8: In standard/fast mode, a change on a line reaches the filtered output only when it persists for at least `FS_FILT_CYC` consecutive synchronised cycles. With the defaults, an 8-cycle or 6-cycle data pulse is dropped.
- R9: In high-speed mode the window is `HS_FILT_CYC` cycles. With the defaults, a 1-cycle pulse is dropped and a 6-cycle data-low pulse with the clock high gets through as a START followed by a STOP.
- R10: Settled levels on the raw lines appear on `scl_filt` and `sda_filt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line |
| scl_filt | output | 1 | Synchronised, deglitched clock line |
| sda_filt | output | 1 | Synchronised, deglitched data line |
| start_pulse | output | 1 | One-cycle START (or repeated START) strobe |
| stop_pulse | output | 1 | One-cycle STOP strobe |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |

## Verification
A wrong capture state or bit count would leave `hs_mode` wrong at the START or STOP strobe that follows. The bench compares `hs_mode` against its own expected value at every strobe. A filter that uses the wrong window shows up within a few cycles of a short pulse, either as a strobe that should not appear or as a missing one. A mode flag that fails to clear after STOP is visible on the very next cycle.

// File: rtl/i2c_spd_pkg.sv
package i2c_spd_pkg;

    localparam int BYTE_BITS = 8;
    localparam logic [4:0] MCODE_PREFIX = 5'b00001;

    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_SHIFT = 2'd1,
        CAP_DONE  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
    } bus_event_t;

    function automatic logic is_master_code(input logic [BYTE_BITS-1:0] b);
        return (b[BYTE_BITS-1 -: 5] == MCODE_PREFIX);
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          raw,
    input  logic [CW-1:0] thr,
    output logic          filt
);
    logic          sync1, sync2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= raw;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b1;
            cnt  <= '0;
        end else if (sync2 == filt) begin
            cnt <= '0;
        end else if (cnt >= thr - 1'b1) begin
            filt <= sync2;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_spd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    output bus_event_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
        ev.scl_rise = scl_f & ~scl_q;
    end
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
    import i2c_spd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_event_t ev,
    input  logic       sda_f,
    output logic       hs_mode
);
    localparam int BCW = $clog2(BYTE_BITS);

    cap_state_e           state;
    logic [BCW-1:0]       bit_cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic [BYTE_BITS-1:0] shreg_nxt;

    assign shreg_nxt = {shreg[BYTE_BITS-2:0], sda_f};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= CAP_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            hs_mode <= 1'b0;
        end else if (ev.stop) begin
            state   <= CAP_IDLE;
            hs_mode <= 1'b0;
        end else if (ev.start) begin
            state   <= CAP_SHIFT;
            bit_cnt <= '0;
        end else if (state == CAP_SHIFT && ev.scl_rise) begin
            shreg   <= shreg_nxt;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == BCW'(BYTE_BITS - 1)) begin
                state <= CAP_DONE;
                if (is_master_code(shreg_nxt))
                    hs_mode <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_speed_tracker.sv
module i2c_speed_tracker
    import i2c_spd_pkg::*;
#(
    parameter int FS_FILT_CYC = 10,
    parameter int HS_FILT_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_filt,
    output logic sda_filt,
    output logic start_pulse,
    output logic stop_pulse,
    output logic hs_mode
);
    localparam int MAXW  = (FS_FILT_CYC > HS_FILT_CYC) ? FS_FILT_CYC : HS_FILT_CYC;
    localparam int CW    = $clog2(MAXW + 1);
    localparam int NLINE = 2;

    logic [CW-1:0]    thr;
    logic [NLINE-1:0] raw_v;
    logic [NLINE-1:0] filt_v;
    bus_event_t       ev;

    assign thr   = hs_mode ? CW'(HS_FILT_CYC) : CW'(FS_FILT_CYC);
    assign raw_v = {scl_in, sda_in};

    for (genvar i = 0; i < NLINE; i++) begin : g_line
        i2c_line_filter #(.CW(CW)) u_flt (
            .clk (clk),
            .rst (rst),
            .raw (raw_v[i]),
            .thr (thr),
            .filt(filt_v[i])
        );
    end

    assign scl_filt = filt_v[1];
    assign sda_filt = filt_v[0];

    i2c_cond_detect u_cond (
        .clk  (clk),
        .rst  (rst),
        .scl_f(scl_filt),
        .sda_f(sda_filt),
        .ev   (ev)
    );

    i2c_mode_ctrl u_mode (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .sda_f  (sda_filt),
        .hs_mode(hs_mode)
    );

    assign start_pulse = ev.start;
    assign stop_pulse  = ev.stop;
endmodule

// File: rtl/i2c_spd_checker.sv
module i2c_spd_checker (
    input logic clk,
    input logic rst,
    input logic scl_filt,
    input logic sda_filt,
    input logic start_pulse,
    input logic stop_pulse,
    input logic hs_mode
);
    AST_RESET_FS: assert property (@(posedge clk) rst |=> !hs_mode); // R1
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse); // R2
    AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (scl_filt && !sda_filt)); // R2
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !stop_pulse); // R3
    AST_STOP_CLEARS_HS: assert property (@(posedge clk) disable iff (rst)
        stop_pulse |=> !hs_mode); // R3
    AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && stop_pulse)); // R4
    AST_HS_ENTRY_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode) |-> scl_filt); // R5
endmodule

bind i2c_speed_tracker i2c_spd_checker u_chk (.*);

// File: tb/sim_i2c_speed_tracker.sv
`timescale 1ns/1ps
module sim_i2c_speed_tracker;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic scl_filt, sda_filt, start_pulse, stop_pulse, hs_mode;

    localparam int Q = 20;

    typedef struct { bit is_stop; bit hs; } ev_t;
    ev_t exp_q[$];

    int n_chk = 0;
    int n_fail = 0;
    bit model_hs = 1'b0;
    bit sda_drop = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    i2c_speed_tracker u0 (
        .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
        .scl_filt(scl_filt), .sda_filt(sda_filt),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .hs_mode(hs_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // monitor: every strobe must match the next expected item
    always @(negedge clk) begin
        if (!rst) begin
            if (!sda_filt) sda_drop = 1'b1;
            if (start_pulse || stop_pulse) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected strobe", {30'd0, stop_pulse, start_pulse}, 0);
                end else begin
                    ev_t e;
                    e = exp_q.pop_front();
                    chk(stop_pulse == e.is_stop, "R2/R3 strobe kind", stop_pulse, e.is_stop);
                    chk(hs_mode == e.hs, "R7 hs at strobe", hs_mode, e.hs);
                end
            end
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input bit is_stop);
        ev_t e;
        e.is_stop = is_stop;
        e.hs = model_hs;
        exp_q.push_back(e);
    endtask

    task automatic bus_start();
        push(1'b0);
        sda_in = 1'b1; wq(Q);
        scl_in = 1'b1; wq(Q);
        sda_in = 1'b0; wq(Q);
        scl_in = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        push(1'b1);
        sda_in = 1'b0; wq(Q);
        scl_in = 1'b1; wq(Q);
        sda_in = 1'b1; wq(Q);
        model_hs = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit first);
        for (int i = 7; i >= 0; i--) begin
            sda_in = b[i]; wq(Q);
            scl_in = 1'b1; wq(2*Q);
            scl_in = 1'b0; wq(Q);
        end
        if (first && b[7:3] == 5'b00001) model_hs = 1'b1;
        sda_in = 1'b1; wq(Q);
        scl_in = 1'b1; wq(2*Q);
        scl_in = 1'b0; wq(Q);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : driver
        wq(6);
        rst = 1'b0;
        wq(1);
        // R1 reset state
        chk(hs_mode == 1'b0, "R1 hs_mode", hs_mode, 0);
        chk(scl_filt && sda_filt, "R1 filtered lines", {scl_filt, sda_filt}, 3);
        chk(!start_pulse && !stop_pulse, "R1 strobes", {start_pulse, stop_pulse}, 0);
        wq(Q);

        // R8 FS rejects an 8-cycle low pulse on data while clock idles high
        sda_drop = 1'b0;
        sda_in = 1'b0; wq(8); sda_in = 1'b1; wq(Q);
        chk(!sda_drop, "R8 fs glitch 8 cyc", sda_drop, 0);

        // R4/R6 normal address byte, then data 0x08 later in the frame
        bus_start();
        send_byte(8'hA0, 1'b1);
        chk(hs_mode == 1'b0, "R6 plain address", hs_mode, 0);
        send_byte(8'h08, 1'b0);
        chk(hs_mode == 1'b0, "R6 late master code", hs_mode, 0);
        bus_stop();
        wq(Q);

        // R5 master code, R7 repeated START keeps HS
        bus_start();
        send_byte(8'h0B, 1'b1);
        chk(hs_mode == 1'b1, "R5 master code", hs_mode, 1);
        bus_start();
        send_byte(8'hA1, 1'b1);
        chk(hs_mode == 1'b1, "R7 after repeated start", hs_mode, 1);
        send_byte(8'h5A, 1'b0);
        bus_stop();
        wq(2);
        chk(hs_mode == 1'b0, "R3 stop returns to fs", hs_mode, 0);
        wq(Q);

        // R9 HS window: 1-cycle pulse dropped, 6-cycle pulse passes
        bus_start();
        send_byte(8'h08, 1'b1);
        chk(hs_mode == 1'b1, "R5 master code 0x08", hs_mode, 1);
        scl_in = 1'b1; wq(Q);
        chk(scl_filt == 1'b1, "R10 scl_filt high", scl_filt, 1);
        sda_drop = 1'b0;
        sda_in = 1'b0; wq(1); sda_in = 1'b1; wq(Q);
        chk(!sda_drop, "R9 hs glitch 1 cyc", sda_drop, 0);
        push(1'b0);
        push(1'b1);
        sda_in = 1'b0; wq(6); sda_in = 1'b1; wq(Q);
        model_hs = 1'b0;
        chk(hs_mode == 1'b0, "R9 hs short pulse stop", hs_mode, 0);

        // R8 the same 6-cycle pulse in FS is dropped
        sda_drop = 1'b0;
        sda_in = 1'b0; wq(6); sda_in = 1'b1; wq(Q);
        chk(!sda_drop, "R8 fs glitch 6 cyc", sda_drop, 0);

        // R10 settled low level passes through
        scl_in = 1'b0; wq(Q);
        chk(scl_filt == 1'b0, "R10 scl_filt low", scl_filt, 0);
        scl_in = 1'b1; wq(Q);

        chk(exp_q.size() == 0, "R2 all strobes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule